// File: doc/BRIEF.md
# Pipeline Interlock and Operand Bypass Controller

This block decides, once per clock, whether a five-stage in-order pipeline (fetch, decode with register read, execute, memory access, write-back; one cycle each) must hold its front end, and from where each of the two execute operands of the next instruction is taken. It looks at the register indices, valid bits and instruction class of the instructions in decode, execute and memory access. From these it drives hold enables for fetch and decode, a bubble insert into execute, and two registered 2-bit select codes that travel with the instruction into execute.

A load's data exists only after its memory-access cycle has finished. An instruction that reads the loaded register straight after the load is therefore held one cycle, and it then takes the value from the memory-access output. An ALU result is taken from the execute output by the very next instruction. The write-data operand of a store is never bypassed. A store whose data register is still in flight waits until the producer reaches write-back, and then reads the value in decode. The small register file included here writes in the first half of a cycle and reads in the second half, so a value in write-back is seen by decode in the same cycle.

A held instruction keeps its decode slot, and the fetch slot behind it is frozen with it. With these rules, a load into a register, then an add of that register to itself, then a subtract that uses the sum, finish write-back of the third instruction in cycle 8, counting fetch of the first as cycle 1.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, both select codes read 00, and with decode invalid no hold or bubble is raised.
- R2: Select codes are 00 = register-file value, 01 = execute-output bypass, 10 = memory-access-output bypass; 11 never appears. A decode source that equals the destination of a valid ALU-class instruction (class 0) in execute gives code 01 for that operand in the following cycle, without a hold.
- R3: A decode source that matches a valid writing instruction (ALU class 0 or load class 1) in memory access, and nothing in execute, gives code 10 in the following cycle.
- R4: When both execute and memory access hold a matching writer, the execute one wins and the code is 01.
- R5: A decode source that is read and matches a valid load (class 1) in execute raises hold-fetch, hold-decode and bubble together in that cycle; the select codes registered at that edge are both 00.
- R6: The data operand (source b) of a store (class 2) is never bypassed: if it matches a writer in execute or memory access, all three holds are raised; a store's source-b code is always 00.
- R7: Non-writing instructions (store class 2, class 3, or invalid) in execute or memory access cause no hold and no bypass; sources a class does not read (source b of a load, both sources of class 3) cause neither.
- R8: A register-file write is visible on a read port with the same index in the same cycle, and is held for later reads.
- R9: Load into R0, then R0 = R0 + R0, then R2 = R2 - R0 completes write-back of the third instruction in cycle 8 with correct R0 and R2.
- R10: With decode invalid, no hold or bubble is raised whatever execute and memory access hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode slot holds an instruction |
| id_cls | input | 2 | Decode class: 0 ALU, 1 load, 2 store, 3 none |
| id_src_a | input | log2(NREG) | Decode first source index (ALU operand, memory address base) |
| id_src_b | input | log2(NREG) | Decode second source index (ALU operand, store data) |
| ex_valid | input | 1 | Execute slot holds an instruction |
| ex_cls | input | 2 | Execute class |
| ex_dst | input | log2(NREG) | Execute destination index |
| ma_valid | input | 1 | Memory-access slot holds an instruction |
| ma_cls | input | 2 | Memory-access class |
| ma_dst | input | log2(NREG) | Memory-access destination index |
| wb_we | input | 1 | Write-back write enable |
| wb_idx | input | log2(NREG) | Write-back register index |
| wb_data | input | XLEN | Write-back data |
| stall_if | output | 1 | Hold the fetch address and fetch/decode register |
| stall_id | output | 1 | Hold the decode slot |
| bubble_ex | output | 1 | Load a no-operation into execute |
| ex_sel_a | output | 2 | Select code for execute operand a |
| ex_sel_b | output | 2 | Select code for execute operand b |
| rd_data_a | output | XLEN | Register value at id_src_a |
| rd_data_b | output | XLEN | Register value at id_src_b |

## Verification
The bench builds the block with its defaults, eight registers of 16 bits. Eight indices leave room to give each stage its own destination in one vector, so a match in execute, a match in memory access, a match in both and a near miss can all be told apart. The 16-bit data let the final register values show whether a stale decode read or a bypassed value was used. A small cycle model wraps the block for the three-instruction sequence and records the cycle in which the last write-back occurs.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

  typedef enum logic [1:0] {
    CLS_ALU   = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_NONE  = 2'd3
  } icls_e;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EXO = 2'b01,
    FWD_MAO = 2'b10
  } fwd_e;

  // An instruction class that produces a register result
  function automatic logic cls_writes(input logic [1:0] c);
    return (c == CLS_ALU) || (c == CLS_LOAD);
  endfunction

endpackage

// File: rtl/hz_reg_file.sv
module hz_reg_file #(
  parameter int NREG  = 8,
  parameter int XLEN  = 16,
  parameter int NRD   = 2,
  localparam int IW   = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [XLEN-1:0]           wr_data,
  input  logic [NRD-1:0][IW-1:0]    rd_idx,
  output logic [NRD-1:0][XLEN-1:0]  rd_data
);

  logic [XLEN-1:0] mem [NREG];

  // Storage array: no reset, written at the clock edge
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // R8: first-half write, second-half read seen as write-through
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = (wr_en && (wr_idx == rd_idx[p])) ? wr_data : mem[rd_idx[p]];
  end

endmodule

// File: rtl/hz_operand_pick.sv
module hz_operand_pick
  import pipe_hazard_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          used,
  input  logic          no_bypass,
  input  logic [IW-1:0] src,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [IW-1:0] ex_dst,
  input  logic          ma_wr,
  input  logic [IW-1:0] ma_dst,
  output logic          hold,
  output logic [1:0]    sel
);

  logic hit_ex;
  logic hit_ma;

  assign hit_ex = used && ex_wr && (ex_dst == src);
  assign hit_ma = used && ma_wr && (ma_dst == src);

  always_comb begin
    hold = 1'b0;
    sel  = FWD_RF;
    if (hit_ex) begin
      // R4: younger producer first; R5: load data not ready yet
      if (no_bypass || ex_load) begin
        hold = 1'b1;
      end else begin
        sel = FWD_EXO;
      end
    end else if (hit_ma) begin
      // R6: store data waits for the split-phase read
      if (no_bypass) begin
        hold = 1'b1;
      end else begin
        sel = FWD_MAO;
      end
    end
  end

endmodule

// File: rtl/hz_sel_reg.sv
module hz_sel_reg #(
  parameter int NOP = 2,
  parameter int SW  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic [NOP-1:0][SW-1:0] sel_in,
  output logic [NOP-1:0][SW-1:0] sel_q
);

  logic [NOP-1:0][SW-1:0] sel_d;

  // Next state: a bubble or an empty decode slot carries no bypass
  always_comb begin
    sel_d = clr ? '0 : sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import pipe_hazard_pkg::*;
#(
  parameter int  NREG = 8,
  parameter int  XLEN = 16,
  localparam int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic [1:0]      id_cls,
  input  logic [IW-1:0]   id_src_a,
  input  logic [IW-1:0]   id_src_b,
  input  logic            ex_valid,
  input  logic [1:0]      ex_cls,
  input  logic [IW-1:0]   ex_dst,
  input  logic            ma_valid,
  input  logic [1:0]      ma_cls,
  input  logic [IW-1:0]   ma_dst,
  input  logic            wb_we,
  input  logic [IW-1:0]   wb_idx,
  input  logic [XLEN-1:0] wb_data,
  output logic            stall_if,
  output logic            stall_id,
  output logic            bubble_ex,
  output logic [1:0]      ex_sel_a,
  output logic [1:0]      ex_sel_b,
  output logic [XLEN-1:0] rd_data_a,
  output logic [XLEN-1:0] rd_data_b
);

  localparam int NOP = 2;
  localparam int SW  = 2;

  logic                   ex_wr;
  logic                   ex_load;
  logic                   ma_wr;
  logic [NOP-1:0]         used;
  logic [NOP-1:0]         no_byp;
  logic [NOP-1:0]         hold;
  logic [NOP-1:0][IW-1:0] src;
  logic [NOP-1:0][SW-1:0] pick;
  logic [NOP-1:0][SW-1:0] sel_q;
  logic [NOP-1:0][XLEN-1:0] rdat;
  logic                   stall;

  // R7: only valid writing classes are producers
  assign ex_wr   = ex_valid && cls_writes(ex_cls);
  assign ex_load = ex_valid && (ex_cls == CLS_LOAD);
  assign ma_wr   = ma_valid && cls_writes(ma_cls);

  assign src[0] = id_src_a;
  assign src[1] = id_src_b;

  // R7, R10: which decode sources are actually read
  assign used[0]   = id_valid && (id_cls != CLS_NONE);
  assign used[1]   = id_valid && ((id_cls == CLS_ALU) || (id_cls == CLS_STORE));
  assign no_byp[0] = 1'b0;
  assign no_byp[1] = (id_cls == CLS_STORE);

  for (genvar g = 0; g < NOP; g++) begin : g_op
    hz_operand_pick #(.IW(IW)) u_pick (
      .used      (used[g]),
      .no_bypass (no_byp[g]),
      .src       (src[g]),
      .ex_wr     (ex_wr),
      .ex_load   (ex_load),
      .ex_dst    (ex_dst),
      .ma_wr     (ma_wr),
      .ma_dst    (ma_dst),
      .hold      (hold[g]),
      .sel       (pick[g])
    );
  end

  // R5, R6: one hold freezes fetch and decode and feeds a bubble
  assign stall     = |hold;
  assign stall_if  = stall;
  assign stall_id  = stall;
  assign bubble_ex = stall;

  hz_sel_reg #(.NOP(NOP), .SW(SW)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (stall || !id_valid),
    .sel_in (pick),
    .sel_q  (sel_q)
  );

  assign ex_sel_a = sel_q[0];
  assign ex_sel_b = sel_q[1];

  hz_reg_file #(.NREG(NREG), .XLEN(XLEN), .NRD(NOP)) u_rf (
    .clk     (clk),
    .wr_en   (wb_we),
    .wr_idx  (wb_idx),
    .wr_data (wb_data),
    .rd_idx  (src),
    .rd_data (rdat)
  );

  assign rd_data_a = rdat[0];
  assign rd_data_b = rdat[1];

endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk
  import pipe_hazard_pkg::*;
#(
  parameter int  NREG = 8,
  localparam int IW   = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          id_valid,
  input logic [1:0]    id_cls,
  input logic [IW-1:0] id_src_a,
  input logic          ex_valid,
  input logic [1:0]    ex_cls,
  input logic [IW-1:0] ex_dst,
  input logic          stall_if,
  input logic          stall_id,
  input logic          bubble_ex,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b
);

  // R10
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !stall_id);

  // R5
  stall_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_if == stall_id) && (bubble_ex == stall_id));

  // R5
  load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && ex_valid && ex_cls == CLS_LOAD && id_cls != CLS_NONE && id_src_a == ex_dst)
    |-> stall_id);

  // R5
  bubble_sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_id |=> (ex_sel_a == FWD_RF && ex_sel_b == FWD_RF));

  // R6
  store_data_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_cls == CLS_STORE) |=> (ex_sel_b == FWD_RF));

  // R4
  ex_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !stall_id && id_cls == CLS_ALU && ex_valid && ex_cls == CLS_ALU &&
     ex_dst == id_src_a) |=> (ex_sel_a == FWD_EXO));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_sel_a != 2'b11) && (ex_sel_b != 2'b11));

endmodule

bind pipe_hazard_unit pipe_hazard_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/pipe_hazard_unit_bench.sv
module pipe_hazard_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] LOAD_VAL = 16'h0123;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_valid;
  logic [1:0]  id_cls;
  logic [2:0]  id_src_a, id_src_b;
  logic        ex_valid;
  logic [1:0]  ex_cls;
  logic [2:0]  ex_dst;
  logic        ma_valid;
  logic [1:0]  ma_cls;
  logic [2:0]  ma_dst;
  logic        wb_we;
  logic [2:0]  wb_idx;
  logic [15:0] wb_data;
  logic        stall_if, stall_id, bubble_ex;
  logic [1:0]  ex_sel_a, ex_sel_b;
  logic [15:0] rd_data_a, rd_data_b;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  pipe_hazard_unit u_pipe_hazard_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, act=%0d exp<=20000 cycles", cyc_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // classes: 0 ALU, 1 load, 2 store, 3 none; codes 00 rf, 01 ex out, 10 ma out
  typedef struct packed {
    logic [1:0] icls; logic [2:0] ia; logic [2:0] ib;
    logic ev; logic [1:0] ecls; logic [2:0] ed;
    logic mv; logic [1:0] mcls; logic [2:0] md;
    logic st; logic [1:0] sa; logic [1:0] sb; logic [3:0] rq;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0,3'd1,3'd2, 1'b1,2'd0,3'd1, 1'b0,2'd0,3'd0, 1'b0,2'b01,2'b00, 4'd2},  // R2 a from ex
    '{2'd0,3'd1,3'd2, 1'b1,2'd0,3'd2, 1'b0,2'd0,3'd0, 1'b0,2'b00,2'b01, 4'd2},  // R2 b from ex
    '{2'd0,3'd3,3'd4, 1'b0,2'd0,3'd4, 1'b1,2'd1,3'd4, 1'b0,2'b00,2'b10, 4'd3},  // R3 load in ma
    '{2'd0,3'd5,3'd5, 1'b1,2'd0,3'd6, 1'b1,2'd0,3'd5, 1'b0,2'b10,2'b10, 4'd3},  // R3 near miss in ex
    '{2'd0,3'd1,3'd1, 1'b1,2'd0,3'd1, 1'b1,2'd1,3'd1, 1'b0,2'b01,2'b01, 4'd4},  // R4 ex wins
    '{2'd0,3'd2,3'd3, 1'b1,2'd1,3'd3, 1'b0,2'd0,3'd0, 1'b1,2'b00,2'b00, 4'd5},  // R5 load-use
    '{2'd2,3'd4,3'd5, 1'b1,2'd1,3'd4, 1'b0,2'd0,3'd0, 1'b1,2'b00,2'b00, 4'd5},  // R5 store address
    '{2'd2,3'd4,3'd5, 1'b1,2'd0,3'd4, 1'b0,2'd0,3'd0, 1'b0,2'b01,2'b00, 4'd2},  // R2 store address bypass
    '{2'd2,3'd4,3'd5, 1'b1,2'd0,3'd5, 1'b0,2'd0,3'd0, 1'b1,2'b00,2'b00, 4'd6},  // R6 data vs ex
    '{2'd2,3'd4,3'd5, 1'b0,2'd0,3'd0, 1'b1,2'd0,3'd5, 1'b1,2'b00,2'b00, 4'd6},  // R6 data vs ma
    '{2'd1,3'd1,3'd6, 1'b1,2'd0,3'd6, 1'b0,2'd0,3'd0, 1'b0,2'b00,2'b00, 4'd7},  // R7 load b unused
    '{2'd0,3'd1,3'd2, 1'b1,2'd2,3'd1, 1'b1,2'd3,3'd2, 1'b0,2'b00,2'b00, 4'd7},  // R7 non-writers
    '{2'd0,3'd1,3'd2, 1'b0,2'd0,3'd1, 1'b0,2'd1,3'd2, 1'b0,2'b00,2'b00, 4'd7},  // R7 invalid stages
    '{2'd3,3'd1,3'd2, 1'b1,2'd1,3'd1, 1'b0,2'd0,3'd0, 1'b0,2'b00,2'b00, 4'd7},  // R7 class 3 reads none
    '{2'd1,3'd3,3'd0, 1'b1,2'd1,3'd3, 1'b0,2'd0,3'd0, 1'b1,2'b00,2'b00, 4'd5}   // R5 load after load
  };

  typedef struct packed {
    logic v; logic [1:0] cls; logic [2:0] d; logic [2:0] a; logic [2:0] b;
    logic sub; logic [1:0] tag;
  } ins_t;

  function automatic logic wr_cls(input logic [1:0] c);
    return (c == 2'd0) || (c == 2'd1);
  endfunction

  function automatic logic [15:0] pick_op(input logic [1:0] s, input logic [15:0] cap,
                                          input logic [15:0] exo, input logic [15:0] mao);
    return (s == 2'b01) ? exo : (s == 2'b10) ? mao : cap;
  endfunction

  initial begin
    ins_t prog [3];
    ins_t id_i, ex_i, ma_i, wb_i, fe;
    logic [15:0] cap_a, cap_b, ma_res, wb_res, res, opa, opb, n_cap_a, n_cap_b;
    logic st;
    int pc, done_cyc, n_stall;

    rst_n = 1'b0;
    id_valid = 0; id_cls = 2'd3; id_src_a = 0; id_src_b = 0;
    ex_valid = 0; ex_cls = 0; ex_dst = 0;
    ma_valid = 0; ma_cls = 0; ma_dst = 0;
    wb_we = 0; wb_idx = 0; wb_data = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(ex_sel_a == 2'b00 && ex_sel_b == 2'b00, "R1 sel in reset", {ex_sel_a, ex_sel_b}, 0);
    chk(!stall_id && !stall_if && !bubble_ex, "R1 no hold in reset", stall_id, 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(ex_sel_a == 2'b00 && ex_sel_b == 2'b00, "R1 sel after reset", {ex_sel_a, ex_sel_b}, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      id_valid = 1; id_cls = VEC[i].icls; id_src_a = VEC[i].ia; id_src_b = VEC[i].ib;
      ex_valid = VEC[i].ev; ex_cls = VEC[i].ecls; ex_dst = VEC[i].ed;
      ma_valid = VEC[i].mv; ma_cls = VEC[i].mcls; ma_dst = VEC[i].md;
      #1;
      chk(stall_id == VEC[i].st, $sformatf("R%0d hold vec %0d", VEC[i].rq, i), stall_id, VEC[i].st);
      chk(stall_if == VEC[i].st && bubble_ex == VEC[i].st,
          $sformatf("R%0d fetch/bubble vec %0d", VEC[i].rq, i), {stall_if, bubble_ex}, {2{VEC[i].st}});
      @(posedge clk); #1;
      chk(ex_sel_a == VEC[i].sa, $sformatf("R%0d sel a vec %0d", VEC[i].rq, i), ex_sel_a, VEC[i].sa);
      chk(ex_sel_b == VEC[i].sb, $sformatf("R%0d sel b vec %0d", VEC[i].rq, i), ex_sel_b, VEC[i].sb);
    end

    // R10: empty decode with a matching load in execute
    @(negedge clk);
    id_valid = 0; id_cls = 2'd0; id_src_a = 3'd3; id_src_b = 3'd3;
    ex_valid = 1; ex_cls = 2'd1; ex_dst = 3'd3; ma_valid = 1; ma_cls = 2'd0; ma_dst = 3'd3;
    #1;
    chk(!stall_id && !stall_if && !bubble_ex, "R10 no hold with empty decode", stall_id, 0);
    @(posedge clk); #1;
    chk(ex_sel_a == 2'b00 && ex_sel_b == 2'b00, "R10 no bypass with empty decode", {ex_sel_a, ex_sel_b}, 0);

    // R8: write-through and retention
    @(negedge clk);
    ex_valid = 0; ma_valid = 0;
    wb_we = 1; wb_idx = 3'd5; wb_data = 16'hABCD; id_src_a = 3'd5;
    #1;
    chk(rd_data_a == 16'hABCD, "R8 same-cycle read", rd_data_a, 16'hABCD);
    @(negedge clk);
    wb_we = 0; wb_data = 16'h0000; id_src_b = 3'd5;
    #1;
    chk(rd_data_b == 16'hABCD, "R8 later read", rd_data_b, 16'hABCD);

    // preset R7 = 0 (address base) and R2 = 0x1000 for R9
    @(negedge clk); wb_we = 1; wb_idx = 3'd7; wb_data = 16'h0000;
    @(negedge clk); wb_we = 1; wb_idx = 3'd2; wb_data = 16'h1000;
    @(negedge clk); wb_we = 0;

    // R9: load R0; R0 = R0 + R0; R2 = R2 - R0
    prog[0] = '{1'b1, 2'd1, 3'd0, 3'd7, 3'd7, 1'b0, 2'd1};
    prog[1] = '{1'b1, 2'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd2};
    prog[2] = '{1'b1, 2'd0, 3'd2, 3'd2, 3'd0, 1'b1, 2'd3};
    id_i = '0; ex_i = '0; ma_i = '0; wb_i = '0;
    cap_a = 0; cap_b = 0; ma_res = 0; wb_res = 0;
    pc = 0; done_cyc = 0; n_stall = 0;
    for (int cyc = 1; cyc <= 12; cyc++) begin
      @(negedge clk);
      id_valid = id_i.v; id_cls = id_i.cls; id_src_a = id_i.a; id_src_b = id_i.b;
      ex_valid = ex_i.v; ex_cls = ex_i.cls; ex_dst = ex_i.d;
      ma_valid = ma_i.v; ma_cls = ma_i.cls; ma_dst = ma_i.d;
      wb_we = wb_i.v && wr_cls(wb_i.cls); wb_idx = wb_i.d; wb_data = wb_res;
      #1;
      st = stall_id;
      if (st) n_stall++;
      n_cap_a = rd_data_a; n_cap_b = rd_data_b;
      if (wb_i.v && wb_i.tag == 2'd3) done_cyc = cyc;
      opa = pick_op(ex_sel_a, cap_a, ma_res, wb_res);
      opb = pick_op(ex_sel_b, cap_b, ma_res, wb_res);
      res = (ex_i.v && ex_i.cls == 2'd0) ? (ex_i.sub ? opa - opb : opa + opb) : 16'hBAD0;
      fe = (pc < 3) ? prog[pc] : '0;
      @(posedge clk);
      wb_res = (ma_i.cls == 2'd1) ? LOAD_VAL : ma_res;
      wb_i = ma_i;
      ma_res = res;
      ma_i = ex_i;
      if (st) begin
        ex_i = '0;
      end else begin
        ex_i = id_i; cap_a = n_cap_a; cap_b = n_cap_b;
        id_i = fe; pc++;
      end
    end
    chk(done_cyc == 8, "R9 third write-back cycle", done_cyc, 8);
    chk(n_stall == 1, "R5 one load-use hold in sequence", n_stall, 1);
    @(negedge clk);
    wb_we = 0; id_valid = 0; ex_valid = 0; ma_valid = 0; id_src_a = 3'd0; id_src_b = 3'd2;
    #1;
    chk(rd_data_a == 16'h0246, "R9 R0 value", rd_data_a, 16'h0246);
    chk(rd_data_b == 16'h0DBA, "R9 R2 value", rd_data_b, 16'h0DBA);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule